// File: doc/BRIEF.md
# Load/Store Address and Data Alignment Unit

This block carries out the data side of one single-register load or store. It takes the base register value, an offset and the transfer control bits. It forms the offset-adjusted base and chooses pre- or post-indexed addressing. It then issues one size-aligned request on a word-wide memory port whose read data arrives one cycle later. It hands back a base-writeback value and a destination-register value, each with its own write strobe.

Loads that are not aligned to their size do not fault. A word load rotates the whole aligned word, and an unsigned halfword load rotates its zero-extended halfword. Byte loads and signed loads pick the addressed lane and extend it. Stores replicate the data across the bus and mark the active lanes with byte enables.

The base writeback is presented in the request cycle and the destination write in the following cycle. A register file that applies both in arrival order therefore keeps the loaded value when the destination and base registers are the same. The block takes one transfer at a time and pulses `done_o` once per transfer.

Top module: `ldst_align_unit`

## Requirements
- R1: The adjusted base is `base_i + offset_i` when `add_off_i` is 1 and `base_i - offset_i` when it is 0, both modulo 2^32.
- R2: The transfer address is the adjusted base when `pre_idx_i` is 1 and `base_i` when it is 0. `mem_addr_o` carries it with bits [1:0] cleared for a word, bit 0 cleared for a halfword, and unchanged for a byte.
- R3: `base_wr_en_o` is asserted in the request cycle exactly when `pre_idx_i` is 0 or `wback_i` is 1, and `base_wr_data_o` then equals the adjusted base.
- R4: A word load (`half_cls_i`=0, `byte_i`=0) returns the read word rotated right by 8 × address[1:0].
- R5: With `half_cls_i`=1 and `half_op_i`=01, a load takes the halfword in lane address[1] (bits [31:16] when 1) and zero-extends it to 32 bits. It then rotates the result right by 8 × address[0].
- R6: With `half_cls_i`=1 and `half_op_i`=10, a load sign-extends bit 7 of the byte in lane address[1:0]. With `half_op_i`=11, it sign-extends bit 15 of the halfword in lane address[1], and address[0] has no effect on the data.
- R7: A byte load (`half_cls_i`=0, `byte_i`=1) zero-extends the byte in lane address[1:0], where lane n is bits [8n+7:8n].
- R8: For a load, `dest_wr_en_o` is asserted one cycle after the request cycle and never in the same cycle as `base_wr_en_o`.
- R9: `half_cls_i`=1 with `half_op_i`=00 is illegal. It gives a one-cycle `illegal_o` pulse together with `done_o` in the cycle after acceptance, with no memory request, no base writeback and no destination write.
- R10: A store asserts `mem_we_o` and never `dest_wr_en_o`. For a byte store, `mem_be_o` has only bit address[1:0] set and `mem_wdata_o` carries the low byte four times. For a halfword store (any legal `half_op_i`), `mem_be_o` is 0011 or 1100 chosen by address[1] and the low halfword is repeated twice. For a word store, `mem_be_o` is 1111 and the data passes unchanged.
- R11: A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both 1. `mem_req_o` follows for one cycle, and `done_o` pulses for one cycle after that. `req_ready_o` is 0 from acceptance until `done_o` has been shown.
- R12: After reset `req_ready_o` is 1 and `mem_req_o`, `base_wr_en_o`, `dest_wr_en_o`, `illegal_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Transfer request |
| req_ready_o | output | 1 | Block idle, request can be taken |
| base_i | input | 32 | Base register value |
| offset_i | input | 32 | Offset, already evaluated |
| pre_idx_i | input | 1 | 1: address is adjusted base; 0: address is base |
| add_off_i | input | 1 | 1: add offset; 0: subtract offset |
| wback_i | input | 1 | Write back adjusted base when pre-indexed |
| load_i | input | 1 | 1: load; 0: store |
| byte_i | input | 1 | Byte size for the word/byte class |
| half_cls_i | input | 1 | Selects the halfword/signed class |
| half_op_i | input | 2 | Halfword-class operation code |
| store_data_i | input | 32 | Data to store |
| mem_req_o | output | 1 | Memory request strobe |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 32 | Size-aligned memory address |
| mem_be_o | output | 4 | Byte enables for a write |
| mem_wdata_o | output | 32 | Lane-replicated write data |
| mem_rdata_i | input | 32 | Read word, valid one cycle after the request |
| base_wr_en_o | output | 1 | Base register write strobe |
| base_wr_data_o | output | 32 | Base register write value |
| dest_wr_en_o | output | 1 | Destination register write strobe |
| dest_wr_data_o | output | 32 | Aligned and extended load result |
| illegal_o | output | 1 | Illegal halfword-class code seen |
| done_o | output | 1 | Transfer finished |

## Verification
The hardest case to reach is a load whose base writeback and destination write both fire. The bench must show that the two strobes land in separate, ordered cycles while each carries the right value. Table vectors combine post-indexing or pre-indexing with writeback and unaligned addresses. The bench samples the request cycle and the response cycle separately. Stores are followed by word loads from the same word, so the byte enables are seen through the merged memory contents as well as on the port.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_RESP  = 2'd2,
    ST_FAULT = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic       pre;
    logic       add;
    logic       wback;
    logic       load;
    logic       sext;
    xfer_size_e size;
  } xfer_ctl_t;

endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
  import ldst_pkg::*;
(
  input  logic       pre_idx_i,
  input  logic       add_off_i,
  input  logic       wback_i,
  input  logic       load_i,
  input  logic       byte_i,
  input  logic       half_cls_i,
  input  logic [1:0] half_op_i,
  output xfer_ctl_t  ctl_o,
  output logic       illegal_o
);

  always_comb begin
    ctl_o.pre   = pre_idx_i;
    ctl_o.add   = add_off_i;
    ctl_o.wback = wback_i;
    ctl_o.load  = load_i;
    ctl_o.sext  = 1'b0;
    ctl_o.size  = SZ_WORD;
    illegal_o   = 1'b0;
    if (half_cls_i) begin
      illegal_o  = (half_op_i == 2'b00);
      ctl_o.sext = load_i & half_op_i[1];
      // signed byte only exists on the load side; stores in this class move a halfword
      ctl_o.size = (load_i && half_op_i == 2'b10) ? SZ_BYTE : SZ_HALF;
    end else begin
      ctl_o.size = byte_i ? SZ_BYTE : SZ_WORD;
    end
  end

endmodule

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen
  import ldst_pkg::*;
#(
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic [DW-1:0]   base_i,
  input  logic [DW-1:0]   offset_i,
  input  xfer_ctl_t       ctl_i,
  output logic [DW-1:0]   mem_addr_o,
  output logic [$clog2(DW/BW)-1:0] addr_lo_o,
  output logic            wb_en_o,
  output logic [DW-1:0]   wb_data_o
);

  localparam int NB   = DW / BW;
  localparam int OFFW = $clog2(NB);

  logic [DW-1:0] adj_base;
  logic [DW-1:0] eff_addr;

  assign adj_base  = ctl_i.add ? (base_i + offset_i) : (base_i - offset_i);
  assign eff_addr  = ctl_i.pre ? adj_base : base_i;
  assign addr_lo_o = eff_addr[OFFW-1:0];

  // post-indexed always writes back; pre-indexed only on request
  assign wb_en_o   = ~ctl_i.pre | ctl_i.wback;
  assign wb_data_o = adj_base;

  always_comb begin
    mem_addr_o = eff_addr;
    unique case (ctl_i.size)
      SZ_WORD: mem_addr_o[OFFW-1:0] = '0;
      SZ_HALF: mem_addr_o[0]        = 1'b0;
      default: ;
    endcase
  end

endmodule

// File: rtl/ldst_store_lanes.sv
module ldst_store_lanes
  import ldst_pkg::*;
#(
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  xfer_size_e                size_i,
  input  logic [$clog2(DW/BW)-1:0]  addr_lo_i,
  input  logic [DW-1:0]             data_i,
  output logic [DW/BW-1:0]          be_o,
  output logic [DW-1:0]             wdata_o
);

  localparam int NB   = DW / BW;
  localparam int HW   = 2 * BW;
  localparam int NH   = NB / 2;
  localparam int OFFW = $clog2(NB);

  logic [OFFW-1:0] half_base;
  assign half_base = {addr_lo_i[OFFW-1:1], 1'b0};

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        be_o    = NB'(1) << addr_lo_i;
        wdata_o = {NB{data_i[BW-1:0]}};
      end
      SZ_HALF: begin
        be_o    = NB'(3) << half_base;
        wdata_o = {NH{data_i[HW-1:0]}};
      end
      default: begin
        be_o    = '1;
        wdata_o = data_i;
      end
    endcase
  end

  always_comb begin
    if (size_i == SZ_BYTE) begin
      AST_BYTE_ONE_LANE: assert ($countones(be_o) == 1); // R10
    end
    if (size_i == SZ_HALF) begin
      AST_HALF_TWO_LANES: assert ($countones(be_o) == 2); // R10
    end
  end

endmodule

// File: rtl/ldst_load_align.sv
module ldst_load_align
  import ldst_pkg::*;
#(
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic [DW-1:0]             rdata_i,
  input  logic [$clog2(DW/BW)-1:0]  addr_lo_i,
  input  xfer_size_e                size_i,
  input  logic                      sext_i,
  output logic [DW-1:0]             result_o
);

  localparam int NB   = DW / BW;
  localparam int HW   = 2 * BW;
  localparam int NH   = NB / 2;
  localparam int OFFW = $clog2(NB);
  localparam int BWL  = $clog2(BW);

  logic [BW-1:0] lane_b [NB];
  logic [HW-1:0] lane_h [NH];

  for (genvar i = 0; i < NB; i++) begin : g_blane
    assign lane_b[i] = rdata_i[i*BW +: BW];
  end
  for (genvar j = 0; j < NH; j++) begin : g_hlane
    assign lane_h[j] = rdata_i[j*HW +: HW];
  end

  logic [BW-1:0]   sel_b;
  logic [HW-1:0]   sel_h;
  logic [DW-1:0]   half_zx;
  logic [2*DW-1:0] word_dbl;
  logic [2*DW-1:0] half_dbl;

  assign sel_b    = lane_b[addr_lo_i];
  assign sel_h    = lane_h[addr_lo_i[OFFW-1:1]];
  assign half_zx  = DW'(sel_h);
  // rotate right by lane count, done as a shift of the doubled value
  assign word_dbl = {rdata_i, rdata_i} >> {addr_lo_i, {BWL{1'b0}}};
  assign half_dbl = {half_zx, half_zx} >> {addr_lo_i[0], {BWL{1'b0}}};

  always_comb begin
    unique case (size_i)
      SZ_BYTE: result_o = sext_i ? {{(DW-BW){sel_b[BW-1]}}, sel_b} : DW'(sel_b);
      SZ_HALF: result_o = sext_i ? {{(DW-HW){sel_h[HW-1]}}, sel_h} : half_dbl[DW-1:0];
      default: result_o = word_dbl[DW-1:0];
    endcase
  end

  always_comb begin
    if (size_i == SZ_BYTE && sext_i) begin
      AST_SBYTE_FILL: assert (result_o[DW-1:BW] == {(DW-BW){rdata_i[addr_lo_i*BW + BW-1]}}); // R6
    end
  end

endmodule

// File: rtl/ldst_align_unit.sv
module ldst_align_unit
  import ldst_pkg::*;
#(
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] offset_i,
  input  logic          pre_idx_i,
  input  logic          add_off_i,
  input  logic          wback_i,
  input  logic          load_i,
  input  logic          byte_i,
  input  logic          half_cls_i,
  input  logic [1:0]    half_op_i,
  input  logic [DW-1:0] store_data_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW/BW-1:0] mem_be_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          base_wr_en_o,
  output logic [DW-1:0] base_wr_data_o,
  output logic          dest_wr_en_o,
  output logic [DW-1:0] dest_wr_data_o,
  output logic          illegal_o,
  output logic          done_o
);

  localparam int NB   = DW / BW;
  localparam int OFFW = $clog2(NB);

  xfer_ctl_t  dec_ctl;
  logic       dec_illegal;
  xfer_ctl_t  ctl_q;
  seq_state_e st_q, st_d;
  logic [DW-1:0] base_q, off_q, sdata_q;
  logic          accept;
  logic [OFFW-1:0] addr_lo;
  logic            wb_en;

  ldst_decode u_dec (
    .pre_idx_i (pre_idx_i),
    .add_off_i (add_off_i),
    .wback_i   (wback_i),
    .load_i    (load_i),
    .byte_i    (byte_i),
    .half_cls_i(half_cls_i),
    .half_op_i (half_op_i),
    .ctl_o     (dec_ctl),
    .illegal_o (dec_illegal)
  );

  assign accept = req_valid_i & (st_q == ST_IDLE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept) st_d = dec_illegal ? ST_FAULT : ST_ISSUE;
      ST_ISSUE: st_d = ST_RESP;
      ST_RESP:  st_d = ST_IDLE;
      ST_FAULT: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ctl_q   <= '0;
      base_q  <= '0;
      off_q   <= '0;
      sdata_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        ctl_q   <= dec_ctl;
        base_q  <= base_i;
        off_q   <= offset_i;
        sdata_q <= store_data_i;
      end
    end
  end

  ldst_addr_gen #(.DW(DW), .BW(BW)) u_agen (
    .base_i    (base_q),
    .offset_i  (off_q),
    .ctl_i     (ctl_q),
    .mem_addr_o(mem_addr_o),
    .addr_lo_o (addr_lo),
    .wb_en_o   (wb_en),
    .wb_data_o (base_wr_data_o)
  );

  ldst_store_lanes #(.DW(DW), .BW(BW)) u_st (
    .size_i   (ctl_q.size),
    .addr_lo_i(addr_lo),
    .data_i   (sdata_q),
    .be_o     (mem_be_o),
    .wdata_o  (mem_wdata_o)
  );

  ldst_load_align #(.DW(DW), .BW(BW)) u_ld (
    .rdata_i  (mem_rdata_i),
    .addr_lo_i(addr_lo),
    .size_i   (ctl_q.size),
    .sext_i   (ctl_q.sext),
    .result_o (dest_wr_data_o)
  );

  assign req_ready_o  = (st_q == ST_IDLE);
  assign mem_req_o    = (st_q == ST_ISSUE);
  assign mem_we_o     = (st_q == ST_ISSUE) & ~ctl_q.load;
  // base first, load result one cycle later: load wins when registers coincide
  assign base_wr_en_o = (st_q == ST_ISSUE) & wb_en;
  assign dest_wr_en_o = (st_q == ST_RESP) & ctl_q.load;
  assign illegal_o    = (st_q == ST_FAULT);
  assign done_o       = (st_q == ST_RESP) | (st_q == ST_FAULT);

  AST_ISSUE_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> $past(req_valid_i && req_ready_o)); // R11
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || dest_wr_en_o) |-> !req_ready_o); // R11
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && req_ready_o); // R11
  AST_DEST_AFTER_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dest_wr_en_o |-> !base_wr_en_o && $past(mem_req_o && !mem_we_o)); // R8
  AST_STORE_NO_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |=> !dest_wr_en_o); // R10
  AST_ILLEGAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !mem_req_o && !base_wr_en_o && !dest_wr_en_o && $past(req_ready_o)); // R9

endmodule

// File: tb/ldst_align_unit_tb.sv
module ldst_align_unit_tb_top;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] off;
    logic        p, u, w, b, hc;
    logic [1:0]  sh;
    logic [31:0] maddr;
    logic        wben;
    logic [31:0] wbv;
    logic [31:0] dest;
  } vec_t;

  localparam int NV = 12;
  // memory word 1 = 8899AABB (addr 4..7), word 2 = 1122F344 (addr 8..B)
  localparam vec_t VEC [NV] = '{
    '{32'h0, 32'h4, 1'b1,1'b1,1'b0,1'b0,1'b0, 2'b00, 32'h4, 1'b0, 32'h4,        32'h8899AABB}, // R1 R2 R4
    '{32'h4, 32'h1, 1'b1,1'b1,1'b1,1'b0,1'b0, 2'b00, 32'h4, 1'b1, 32'h5,        32'hBB8899AA}, // R3 R4
    '{32'h7, 32'h8, 1'b0,1'b0,1'b0,1'b0,1'b0, 2'b00, 32'h4, 1'b1, 32'hFFFFFFFF, 32'h99AABB88}, // R1 wrap, post
    '{32'h6, 32'h0, 1'b1,1'b1,1'b0,1'b0,1'b1, 2'b01, 32'h6, 1'b0, 32'h6,        32'h00008899}, // R5
    '{32'h4, 32'h1, 1'b1,1'b1,1'b0,1'b0,1'b1, 2'b01, 32'h4, 1'b0, 32'h5,        32'hBB0000AA}, // R5 rotate
    '{32'h8, 32'h1, 1'b1,1'b0,1'b0,1'b0,1'b1, 2'b10, 32'h7, 1'b0, 32'h7,        32'hFFFFFF88}, // R6 byte neg
    '{32'h8, 32'h0, 1'b0,1'b1,1'b0,1'b0,1'b1, 2'b10, 32'h8, 1'b1, 32'h8,        32'h00000044}, // R6 byte pos
    '{32'h9, 32'h0, 1'b1,1'b1,1'b0,1'b0,1'b1, 2'b11, 32'h8, 1'b0, 32'h9,        32'hFFFFF344}, // R6 half odd
    '{32'hA, 32'h0, 1'b1,1'b1,1'b0,1'b0,1'b1, 2'b11, 32'hA, 1'b0, 32'hA,        32'h00001122}, // R6 half pos
    '{32'h6, 32'h0, 1'b1,1'b1,1'b0,1'b1,1'b0, 2'b00, 32'h6, 1'b0, 32'h6,        32'h00000099}, // R7
    '{32'h10,32'h8, 1'b1,1'b0,1'b1,1'b0,1'b0, 2'b00, 32'h8, 1'b1, 32'h8,        32'h1122F344}, // R3 R8
    '{32'hB, 32'h0, 1'b1,1'b1,1'b0,1'b0,1'b0, 2'b00, 32'h8, 1'b0, 32'hB,        32'h22F34411}  // R4 rot 24
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid, req_ready;
  logic [31:0] base, offset, sdata;
  logic        pre, add, wback, load, byt, hcls;
  logic [1:0]  hop;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic [31:0] mem_rdata;
  logic        base_we, dest_we, illegal, done;
  logic [31:0] base_wd, dest_wd;

  int n_chk = 0;
  int n_err = 0;

  ldst_align_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .base_i(base), .offset_i(offset),
    .pre_idx_i(pre), .add_off_i(add), .wback_i(wback),
    .load_i(load), .byte_i(byt), .half_cls_i(hcls), .half_op_i(hop),
    .store_data_i(sdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_be_o(mem_be), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .base_wr_en_o(base_we), .base_wr_data_o(base_wd),
    .dest_wr_en_o(dest_we), .dest_wr_data_o(dest_wd),
    .illegal_o(illegal), .done_o(done)
  );

  logic [31:0] mem [16];

  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      for (int i = 0; i < 4; i++)
        if (mem_be[i]) mem[mem_addr[5:2]][i*8 +: 8] <= mem_wdata[i*8 +: 8];
    end
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[5:2]];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic start(input logic [31:0] b_v, input logic [31:0] o_v,
                       input logic p_v, input logic u_v, input logic w_v,
                       input logic l_v, input logic by_v, input logic hc_v,
                       input logic [1:0] sh_v, input logic [31:0] sd_v);
    @(negedge clk);
    base = b_v; offset = o_v; pre = p_v; add = u_v; wback = w_v;
    load = l_v; byt = by_v; hcls = hc_v; hop = sh_v; sdata = sd_v;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R11 watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    req_valid = 0; base = 0; offset = 0; sdata = 0;
    pre = 0; add = 0; wback = 0; load = 0; byt = 0; hcls = 0; hop = 0;
    mem_rdata = 0;
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    mem[1] = 32'h8899AABB;
    mem[2] = 32'h1122F344;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 ready",   32'(req_ready), 32'd1);
    chk("R12 mem_req", 32'(mem_req),   32'd0);
    chk("R12 strobes", {28'd0, base_we, dest_we, illegal, done}, 32'd0);
    rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = VEC[k];
      start(v.base, v.off, v.p, v.u, v.w, 1'b1, v.b, v.hc, v.sh, 32'h0);
      chk("R11 busy",     32'(req_ready), 32'd0);
      chk("R11 mem_req",  32'(mem_req),   32'd1);
      chk("R2 mem_addr",  mem_addr,       v.maddr);
      chk("R3 wb_en",     32'(base_we),   32'(v.wben));
      if (v.wben) chk("R1 R3 wb_data", base_wd, v.wbv);
      chk("R8 no dest in request cycle", 32'(dest_we), 32'd0);
      @(negedge clk);
      chk("R8 dest_en",   32'(dest_we), 32'd1);
      chk("R8 no base in dest cycle", 32'(base_we), 32'd0);
      chk("R4 R5 R6 R7 load data", dest_wd, v.dest);
      chk("R11 done",     32'(done), 32'd1);
      @(negedge clk);
      chk("R11 ready after done", {30'd0, req_ready, done}, 32'd2);
    end

    // R10 byte store at 5
    start(32'h5, 32'h0, 1, 1, 0, 0, 1, 0, 2'b00, 32'h000000CD);
    chk("R10 we",       32'(mem_we), 32'd1);
    chk("R10 be byte",  32'(mem_be), 32'h2);
    chk("R10 wd byte",  mem_wdata,   32'hCDCDCDCD);
    chk("R2 byte addr", mem_addr,    32'h5);
    @(negedge clk);
    chk("R10 no dest",  32'(dest_we), 32'd0);
    chk("R11 store done", 32'(done), 32'd1);
    start(32'h4, 32'h0, 1, 1, 0, 1, 0, 0, 2'b00, 32'h0);
    @(negedge clk);
    chk("R10 byte merge", dest_wd, 32'h8899CDBB);

    // R10 halfword store at 6
    start(32'h6, 32'h0, 1, 1, 0, 0, 0, 1, 2'b01, 32'hFFFF1234);
    chk("R10 be half",  32'(mem_be), 32'hC);
    chk("R10 wd half",  mem_wdata,   32'h12341234);
    @(negedge clk);
    start(32'h4, 32'h0, 1, 1, 0, 1, 0, 0, 2'b00, 32'h0);
    @(negedge clk);
    chk("R10 half merge", dest_wd, 32'h1234CDBB);

    // R10 word store, post-indexed writeback R3
    start(32'h8, 32'h4, 0, 1, 0, 0, 0, 0, 2'b00, 32'hDEADBEEF);
    chk("R10 be word",  32'(mem_be), 32'hF);
    chk("R10 wd word",  mem_wdata,   32'hDEADBEEF);
    chk("R3 post wb_en", 32'(base_we), 32'd1);
    chk("R3 post wb",   base_wd,     32'hC);
    @(negedge clk);
    chk("R10 word no dest", 32'(dest_we), 32'd0);
    start(32'h8, 32'h0, 1, 1, 0, 1, 0, 0, 2'b00, 32'h0);
    @(negedge clk);
    chk("R10 word merge", dest_wd, 32'hDEADBEEF);

    // R9 illegal halfword-class code
    start(32'h4, 32'h4, 0, 1, 1, 1, 0, 1, 2'b00, 32'h0);
    chk("R9 illegal",  32'(illegal), 32'd1);
    chk("R9 done",     32'(done),    32'd1);
    chk("R9 quiet",    {29'd0, mem_req, base_we, dest_we}, 32'd0);
    @(negedge clk);
    chk("R9 pulse ends", {30'd0, illegal, req_ready}, 32'd1);
    chk("R9 no mem after", 32'(mem_req), 32'd0);

    finish_run();
  end

endmodule